// File: doc/BRIEF.md
# SCSI Bus Controller Register Interface

This block is the host-facing register file of a SCSI protocol controller. The host reaches eight byte-wide registers through a 3-bit address and separate read and write strobes. A read and a write at the same address reach different functions. The stored command registers drive the SCSI control and data lines directly. Status reads combine stored bits with the live state of the bus lines.

The block checks the bus phase lines against the target command register. It tracks DMA mode and an end-of-DMA condition taken from the host-side DMA pins. When the block is an initiator in DMA mode and the target raises REQ on a phase that does not match, the block raises an interrupt. A one-byte request/acknowledge handshake lets the host move bytes in DMA send and DMA initiator-receive operations. The arbitration status flags come in from outside as inputs.

Top module: `scsi_ctrl_regs`

## Requirements
- R1: On a synchronous reset, every register, flag, driven line and DMA state is zero. Address 2 reads back the mode byte as written, and address 3 reads back the target command byte as written.
- R2: A write to address 1 stores the initiator command byte and drives the bus lines from it: bit 7 drives RST, bit 4 ACK, bit 3 BSY, bit 2 SEL and bit 1 ATN. Each line is rebuilt on every write. A read of address 1 returns the stored byte with bit 6 replaced by the arbitration-in-progress input and bit 5 replaced by the lost-arbitration input.
- R3: Target command bits drive the bus lines as follows: bit 3 drives REQ, bit 2 MSG, bit 1 C/D and bit 0 I/O.
- R4: A write to address 0 loads the output data byte. Reads of address 0 and address 6 return the live bus data byte.
- R5: A read of address 4 returns the live control lines: bit 7 RST, bit 6 BSY, bit 5 REQ, bit 4 MSG, bit 3 C/D, bit 2 I/O, bit 1 SEL and bit 0 parity.
- R6: A read of address 5 returns bit 7 end-of-DMA, bit 6 DMA request, bit 4 interrupt, bit 3 phase match, bit 1 bus ATN and bit 0 bus ACK. All other bits are 0.
- R7: Phase match is 1 exactly when the bus MSG, C/D and I/O lines equal target command bits 2, 1 and 0.
- R8: A write to address 5, 6 or 7 selects DMA send, DMA target receive or DMA initiator receive, and the written data is ignored. DMA mode is mode bit 1. When DMA mode is on, an operation is selected, bus REQ is high and no acknowledge is pending, the DMA request output rises one cycle later.
- R9: In send, a write to address 0 while the DMA request is high clears the request and asserts ACK on the bus. ACK is released the cycle after bus REQ is seen low.
- R10: In initiator receive, a read of address 0 while the DMA request is high returns the bus data, clears the request and asserts ACK, as in R9.
- R11: End-of-DMA sets after EOP, DACK and (RD or WR) have been high together for EOP_CYCLES consecutive cycles. A mode write with bit 1 = 0 clears end-of-DMA, the DMA request and the selected operation.
- R12: The interrupt output is active-high. It sets when DMA mode is on, mode bit 6 (target role) is 0, bus REQ rises and phase match is 0. It then holds.
- R13: A read of address 7 clears the interrupt, unless a new interrupt event occurs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational) |
| arb_active | input | 1 | Arbitration in progress |
| arb_lost | input | 1 | Arbitration lost |
| bus_data_in | input | 8 | SCSI data lines as sensed |
| bus_rst_in | input | 1 | Sensed RST |
| bus_bsy_in | input | 1 | Sensed BSY |
| bus_req_in | input | 1 | Sensed REQ |
| bus_msg_in | input | 1 | Sensed MSG |
| bus_cd_in | input | 1 | Sensed C/D |
| bus_io_in | input | 1 | Sensed I/O |
| bus_sel_in | input | 1 | Sensed SEL |
| bus_par_in | input | 1 | Sensed parity |
| bus_atn_in | input | 1 | Sensed ATN |
| bus_ack_in | input | 1 | Sensed ACK |
| bus_data_out | output | 8 | Output data byte |
| drv_rst | output | 1 | Drive RST |
| drv_ack | output | 1 | Drive ACK |
| drv_bsy | output | 1 | Drive BSY |
| drv_sel | output | 1 | Drive SEL |
| drv_atn | output | 1 | Drive ATN |
| drv_req | output | 1 | Drive REQ |
| drv_msg | output | 1 | Drive MSG |
| drv_cd | output | 1 | Drive C/D |
| drv_io | output | 1 | Drive I/O |
| dma_eop | input | 1 | Host end-of-process |
| dma_dack | input | 1 | Host DMA acknowledge |
| dma_rd | input | 1 | Host DMA read strobe |
| dma_wr | input | 1 | Host DMA write strobe |
| dma_req | output | 1 | DMA request to host |
| irq | output | 1 | Interrupt, active-high |

## Verification
The bench builds the block with EOP_CYCLES set to 3. At that value a two-cycle end-of-DMA pulse, which must not set the flag, and a full three-cycle pulse, which must set it, each fit in a few cycles. The same window also lets the flag be cleared by a mode write soon after. The interrupt cases place a REQ rise under matching and mismatching phases, and under both the initiator role and the target role.

// File: rtl/scsi_regs_pkg.sv
package scsi_regs_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_SEND  = 2'd1,
        OP_TRECV = 2'd2,
        OP_IRECV = 2'd3
    } dma_op_t;

    localparam logic [2:0] A_DATA   = 3'd0;
    localparam logic [2:0] A_ICMD   = 3'd1;
    localparam logic [2:0] A_MODE   = 3'd2;
    localparam logic [2:0] A_TCMD   = 3'd3;
    localparam logic [2:0] A_CTRL   = 3'd4;
    localparam logic [2:0] A_STAT   = 3'd5;
    localparam logic [2:0] A_INDATA = 3'd6;
    localparam logic [2:0] A_CLEAR  = 3'd7;

    localparam int MODE_DMA_BIT    = 1;
    localparam int MODE_TARGET_BIT = 6;
    localparam logic [7:0] ICMD_KEEP_MASK = 8'h9F;

    typedef struct packed {
        logic rst;
        logic bsy;
        logic req;
        logic msg;
        logic cd;
        logic io;
        logic sel;
        logic par;
        logic atn;
        logic ack;
    } scsi_lines_t;

    typedef struct packed {
        logic wr;
        logic rd;
        logic [2:0] addr;
        logic [7:0] wdata;
    } host_acc_t;

    function automatic logic phase_equal(input scsi_lines_t ln, input logic [2:0] tphase);
        return {ln.msg, ln.cd, ln.io} == tphase;
    endfunction

    function automatic logic [7:0] ctrl_snapshot(input scsi_lines_t ln);
        return {ln.rst, ln.bsy, ln.req, ln.msg, ln.cd, ln.io, ln.sel, ln.par};
    endfunction

endpackage

// File: rtl/scsi_drive_ctl.sv
module scsi_drive_ctl
    import scsi_regs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  host_acc_t  acc,
    output logic [7:0] icmd_q,
    output logic [7:0] mode_q,
    output logic [7:0] tcmd_q,
    output logic [7:0] dout_q,
    output logic       o_rst,
    output logic       o_ack_cmd,
    output logic       o_bsy,
    output logic       o_sel,
    output logic       o_atn,
    output logic       o_req,
    output logic       o_msg,
    output logic       o_cd,
    output logic       o_io
);
    always_ff @(posedge clk) begin
        if (rst) begin
            icmd_q <= '0;
            mode_q <= '0;
            tcmd_q <= '0;
            dout_q <= '0;
        end else if (acc.wr) begin
            case (acc.addr)
                A_DATA: dout_q <= acc.wdata;
                A_ICMD: icmd_q <= acc.wdata & ICMD_KEEP_MASK;
                A_MODE: mode_q <= acc.wdata;
                A_TCMD: tcmd_q <= acc.wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        o_rst     = icmd_q[7];
        o_ack_cmd = icmd_q[4];
        o_bsy     = icmd_q[3];
        o_sel     = icmd_q[2];
        o_atn     = icmd_q[1];
        o_req     = tcmd_q[3];
        o_msg     = tcmd_q[2];
        o_cd      = tcmd_q[1];
        o_io      = tcmd_q[0];
    end

    assert_icmd_bsy_R2: assert property (@(posedge clk) disable iff (rst)
        (acc.wr && acc.addr == A_ICMD) |=> (o_bsy == $past(acc.wdata[3])));
    assert_tcmd_req_R3: assert property (@(posedge clk) disable iff (rst)
        (acc.wr && acc.addr == A_TCMD) |=> (o_req == $past(acc.wdata[3])));
endmodule

// File: rtl/scsi_dma_engine.sv
module scsi_dma_engine
    import scsi_regs_pkg::*;
#(
    parameter int EOP_CYCLES = 5
) (
    input  logic      clk,
    input  logic      rst,
    input  host_acc_t acc,
    input  logic      dma_mode,
    input  logic      bus_req,
    input  logic      eop,
    input  logic      dack,
    input  logic      hrd,
    input  logic      hwr,
    output logic      req_q,
    output logic      ack_q,
    output logic      eod_q
);
    localparam int CW = $clog2(EOP_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(EOP_CYCLES - 1);

    dma_op_t       op_q;
    logic [CW-1:0] cnt_q;
    logic          complete, mode_clear, eod_cond, want_req;

    always_comb begin
        complete = req_q && acc.addr == A_DATA &&
                   ((acc.wr && op_q == OP_SEND) || (acc.rd && op_q == OP_IRECV));
        mode_clear = acc.wr && acc.addr == A_MODE && !acc.wdata[MODE_DMA_BIT];
        eod_cond   = eop && dack && (hrd || hwr);
        want_req   = dma_mode && op_q != OP_IDLE && bus_req && !ack_q && !req_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q <= OP_IDLE;
        end else if (mode_clear) begin
            op_q <= OP_IDLE;
        end else if (acc.wr) begin
            case (acc.addr)
                A_STAT:   op_q <= OP_SEND;
                A_INDATA: op_q <= OP_TRECV;
                A_CLEAR:  op_q <= OP_IRECV;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= 1'b0;
            ack_q <= 1'b0;
        end else begin
            if (complete) begin
                req_q <= 1'b0;
                ack_q <= 1'b1;
            end else if (ack_q && !bus_req) begin
                ack_q <= 1'b0;
            end else if (want_req) begin
                req_q <= 1'b1;
            end
            if (mode_clear) req_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            eod_q <= 1'b0;
        end else begin
            if (!eod_cond) begin
                cnt_q <= '0;
            end else if (cnt_q != LAST) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (mode_clear) begin
                eod_q <= 1'b0;
            end else if (eod_cond && cnt_q == LAST) begin
                eod_q <= 1'b1;
            end
        end
    end

    assert_req_done_R9: assert property (@(posedge clk) disable iff (rst)
        (req_q && acc.wr && acc.addr == A_DATA && op_q == OP_SEND) |=> (!req_q && ack_q));
    assert_ack_release_R9: assert property (@(posedge clk) disable iff (rst)
        (ack_q && !bus_req && !req_q) |=> !ack_q);
    assert_eod_clear_R11: assert property (@(posedge clk) disable iff (rst)
        mode_clear |=> (!eod_q && !req_q));
    assert_eod_needs_cond_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(eod_q) |-> $past(eod_cond));
endmodule

// File: rtl/scsi_irq_unit.sv
module scsi_irq_unit
    import scsi_regs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  host_acc_t   acc,
    input  logic [7:0]  mode,
    input  logic [2:0]  tphase,
    input  scsi_lines_t lines,
    output logic        match,
    output logic        irq_q
);
    logic req_prev_q, req_rise, set_irq, clr_irq;

    always_comb begin
        match    = phase_equal(lines, tphase);
        req_rise = lines.req && !req_prev_q;
        set_irq  = mode[MODE_DMA_BIT] && !mode[MODE_TARGET_BIT] && req_rise && !match;
        clr_irq  = acc.rd && acc.addr == A_CLEAR;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_prev_q <= 1'b0;
            irq_q      <= 1'b0;
        end else begin
            req_prev_q <= lines.req;
            if (set_irq)      irq_q <= 1'b1;
            else if (clr_irq) irq_q <= 1'b0;
        end
    end

    assert_irq_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (irq_q && !clr_irq) |=> irq_q);
    assert_irq_clear_R13: assert property (@(posedge clk) disable iff (rst)
        (clr_irq && !(lines.req && !req_prev_q)) |=> !irq_q);
    assert_irq_cause_R12: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_q) |-> $past(mode[MODE_DMA_BIT] && lines.req));
endmodule

// File: rtl/scsi_ctrl_regs.sv
module scsi_ctrl_regs
    import scsi_regs_pkg::*;
#(
    parameter int EOP_CYCLES = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] reg_addr,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       arb_active,
    input  logic       arb_lost,
    input  logic [7:0] bus_data_in,
    input  logic       bus_rst_in,
    input  logic       bus_bsy_in,
    input  logic       bus_req_in,
    input  logic       bus_msg_in,
    input  logic       bus_cd_in,
    input  logic       bus_io_in,
    input  logic       bus_sel_in,
    input  logic       bus_par_in,
    input  logic       bus_atn_in,
    input  logic       bus_ack_in,
    output logic [7:0] bus_data_out,
    output logic       drv_rst,
    output logic       drv_ack,
    output logic       drv_bsy,
    output logic       drv_sel,
    output logic       drv_atn,
    output logic       drv_req,
    output logic       drv_msg,
    output logic       drv_cd,
    output logic       drv_io,
    input  logic       dma_eop,
    input  logic       dma_dack,
    input  logic       dma_rd,
    input  logic       dma_wr,
    output logic       dma_req,
    output logic       irq
);
    host_acc_t   acc;
    scsi_lines_t lines;
    logic [7:0]  icmd, mode, tcmd;
    logic        ack_cmd, ack_dma, eod, match;

    always_comb begin
        acc   = '{wr: reg_wr, rd: reg_rd, addr: reg_addr, wdata: reg_wdata};
        lines = '{rst: bus_rst_in, bsy: bus_bsy_in, req: bus_req_in, msg: bus_msg_in,
                  cd: bus_cd_in, io: bus_io_in, sel: bus_sel_in, par: bus_par_in,
                  atn: bus_atn_in, ack: bus_ack_in};
    end

    scsi_drive_ctl u_drive (
        .clk(clk), .rst(rst), .acc(acc),
        .icmd_q(icmd), .mode_q(mode), .tcmd_q(tcmd), .dout_q(bus_data_out),
        .o_rst(drv_rst), .o_ack_cmd(ack_cmd), .o_bsy(drv_bsy), .o_sel(drv_sel),
        .o_atn(drv_atn), .o_req(drv_req), .o_msg(drv_msg), .o_cd(drv_cd), .o_io(drv_io)
    );

    scsi_dma_engine #(.EOP_CYCLES(EOP_CYCLES)) u_dma (
        .clk(clk), .rst(rst), .acc(acc), .dma_mode(mode[MODE_DMA_BIT]),
        .bus_req(bus_req_in), .eop(dma_eop), .dack(dma_dack), .hrd(dma_rd), .hwr(dma_wr),
        .req_q(dma_req), .ack_q(ack_dma), .eod_q(eod)
    );

    scsi_irq_unit u_irq (
        .clk(clk), .rst(rst), .acc(acc), .mode(mode), .tphase(tcmd[2:0]),
        .lines(lines), .match(match), .irq_q(irq)
    );

    assign drv_ack = ack_cmd | ack_dma;

    always_comb begin
        case (reg_addr)
            A_DATA:   reg_rdata = bus_data_in;
            A_ICMD:   reg_rdata = (icmd & ICMD_KEEP_MASK) | {1'b0, arb_active, arb_lost, 5'b0};
            A_MODE:   reg_rdata = mode;
            A_TCMD:   reg_rdata = tcmd;
            A_CTRL:   reg_rdata = ctrl_snapshot(lines);
            A_STAT:   reg_rdata = {eod, dma_req, 1'b0, irq, match, 1'b0, lines.atn, lines.ack};
            A_INDATA: reg_rdata = bus_data_in;
            default:  reg_rdata = 8'h00;
        endcase
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!irq && !dma_req && !drv_bsy && !drv_req && bus_data_out == 8'h00));
    assert_ack_follows_R9: assert property (@(posedge clk) disable iff (rst)
        ($fell(dma_req) && $past(reg_wr && reg_addr == A_DATA)) |-> drv_ack);
endmodule

// File: tb/scsi_ctrl_regs_tb.sv
module scsi_ctrl_regs_tb;
    localparam int N = 3;

    logic clk = 0, rst = 1;
    logic [2:0] a = 0;
    logic wr = 0, rd = 0;
    logic [7:0] wd = 0, rdata, dout;
    logic arb_a = 0, arb_l = 0;
    logic [7:0] bd = 0;
    logic b_rst = 0, b_bsy = 0, b_req = 0, b_msg = 0, b_cd = 0, b_io = 0, b_sel = 0, b_par = 0, b_atn = 0, b_ack = 0;
    logic d_rst, d_ack, d_bsy, d_sel, d_atn, d_req, d_msg, d_cd, d_io;
    logic eop = 0, dack = 0, hrd = 0, hwr = 0, dreq, irq;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 0;

    always #10 clk = ~clk;

    scsi_ctrl_regs #(.EOP_CYCLES(N)) u_dut (
        .clk(clk), .rst(rst), .reg_addr(a), .reg_wr(wr), .reg_rd(rd), .reg_wdata(wd),
        .reg_rdata(rdata), .arb_active(arb_a), .arb_lost(arb_l), .bus_data_in(bd),
        .bus_rst_in(b_rst), .bus_bsy_in(b_bsy), .bus_req_in(b_req), .bus_msg_in(b_msg),
        .bus_cd_in(b_cd), .bus_io_in(b_io), .bus_sel_in(b_sel), .bus_par_in(b_par),
        .bus_atn_in(b_atn), .bus_ack_in(b_ack), .bus_data_out(dout),
        .drv_rst(d_rst), .drv_ack(d_ack), .drv_bsy(d_bsy), .drv_sel(d_sel), .drv_atn(d_atn),
        .drv_req(d_req), .drv_msg(d_msg), .drv_cd(d_cd), .drv_io(d_io),
        .dma_eop(eop), .dma_dack(dack), .dma_rd(hrd), .dma_wr(hwr), .dma_req(dreq), .irq(irq)
    );

    // reference model state
    logic [7:0] m_icmd = 0, m_mode = 0, m_tcmd = 0, m_dout = 0;
    int m_op = 0;          // 0 idle 1 send 2 target recv 3 initiator recv
    bit m_dreq = 0, m_dack = 0, m_eod = 0, m_irq = 0, m_prev = 0;
    int m_cnt = 0;

    function automatic bit pm();
        return ({b_msg, b_cd, b_io} == m_tcmd[2:0]);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_icmd = 0; m_mode = 0; m_tcmd = 0; m_dout = 0; m_op = 0;
            m_dreq = 0; m_dack = 0; m_eod = 0; m_irq = 0; m_prev = 0; m_cnt = 0;
        end else begin
            bit done_x, mclr, cond, rise, n_dreq, n_dack, n_eod, n_irq;
            int n_op, n_cnt;
            done_x = m_dreq && a == 0 && ((wr && m_op == 1) || (rd && m_op == 3));
            mclr = wr && a == 2 && !wd[1];
            cond = eop && dack && (hrd || hwr);
            n_dreq = m_dreq; n_dack = m_dack;
            if (done_x) begin n_dreq = 0; n_dack = 1; end
            else if (m_dack && !b_req) n_dack = 0;
            else if (m_mode[1] && m_op != 0 && b_req && !m_dack && !m_dreq) n_dreq = 1;
            if (mclr) n_dreq = 0;
            n_cnt = cond ? ((m_cnt + 1 > N - 1) ? N - 1 : m_cnt + 1) : 0;
            n_eod = m_eod;
            if (cond && m_cnt + 1 >= N) n_eod = 1;
            if (mclr) n_eod = 0;
            rise = b_req && !m_prev;
            n_irq = m_irq;
            if (m_mode[1] && !m_mode[6] && rise && !pm()) n_irq = 1;
            else if (rd && a == 7) n_irq = 0;
            n_op = m_op;
            if (mclr) n_op = 0;
            else if (wr && a >= 5) n_op = a - 4;
            if (wr) case (a)
                0: m_dout = wd;
                1: m_icmd = wd & 8'h9F;
                2: m_mode = wd;
                3: m_tcmd = wd;
                default: ;
            endcase
            m_dreq = n_dreq; m_dack = n_dack; m_eod = n_eod; m_cnt = n_cnt;
            m_irq = n_irq; m_prev = b_req; m_op = n_op;
        end
    end

    function automatic logic [7:0] exp_rd();
        case (a)
            0, 6: return bd;
            1: return m_icmd | {1'b0, arb_a, arb_l, 5'b0};
            2: return m_mode;
            3: return m_tcmd;
            4: return {b_rst, b_bsy, b_req, b_msg, b_cd, b_io, b_sel, b_par};
            5: return {m_eod, m_dreq, 1'b0, m_irq, pm(), 1'b0, b_atn, b_ack};
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d actual %02h expected %02h", req, cyc, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            chk("R2 line drive", {d_rst, d_bsy, d_sel, d_atn}, {m_icmd[7], m_icmd[3], m_icmd[2], m_icmd[1]});
            chk("R3 target drive", {d_req, d_msg, d_cd, d_io}, m_tcmd[3:0]);
            chk("R4 data out", dout, m_dout);
            chk("R9 R10 ack drive", {7'b0, d_ack}, {7'b0, m_icmd[4] | m_dack});
            chk("R8 dma request", {7'b0, dreq}, {7'b0, m_dreq});
            chk("R12 R13 irq", {7'b0, irq}, {7'b0, m_irq});
            if (rd) begin
                case (a)
                    1: chk("R2 icmd read", rdata, exp_rd());
                    2, 3: chk("R1 reg read", rdata, exp_rd());
                    4: chk("R5 ctrl read", rdata, exp_rd());
                    5: chk("R6 R7 R11 status read", rdata, exp_rd());
                    0: chk("R4 R10 data read", rdata, exp_rd());
                    default: chk("R4 R13 read", rdata, exp_rd());
                endcase
            end
        end
    end

    task automatic step(); @(posedge clk); #2; endtask
    task automatic wreg(input logic [2:0] ad, input logic [7:0] d);
        a = ad; wd = d; wr = 1; step(); wr = 0;
    endtask
    task automatic rreg(input logic [2:0] ad);
        a = ad; rd = 1; step(); rd = 0;
    endtask
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        idle(2);
        @(negedge clk);
        chk("R1 reset irq", {6'b0, irq, dreq}, 8'h00);
        chk("R1 reset lines", {d_rst, d_ack, d_bsy, d_sel, d_atn, d_req, d_msg, d_cd}, 8'h00);
        chk("R1 reset dout", dout, 8'h00);
        step(); rst = 0;
        // R1 / R2 / R3 register patterns
        rreg(2); rreg(3);
        wreg(2, 8'h80); rreg(2);
        wreg(3, 8'h0F); rreg(3);
        wreg(3, 8'h05); wreg(1, 8'hFF); arb_a = 1; rreg(1); arb_l = 1; arb_a = 0; rreg(1);
        wreg(1, 8'h12); rreg(1); wreg(1, 8'h00); arb_l = 0;
        // R4 / R5
        wreg(0, 8'h3C); bd = 8'hA7; rreg(0); rreg(6);
        {b_rst, b_bsy, b_req, b_msg, b_cd, b_io, b_sel, b_par} = 8'b1010_0101; rreg(4);
        {b_rst, b_bsy, b_req, b_msg, b_cd, b_io, b_sel, b_par} = 8'b0101_1010; rreg(4);
        {b_rst, b_bsy, b_req, b_sel, b_par} = 0;
        // R6 / R7 phase match patterns
        for (int p = 0; p < 8; p++) begin
            {b_msg, b_cd, b_io} = 3'(p); b_atn = p[0]; b_ack = p[1]; rreg(5);
        end
        b_atn = 0; b_ack = 0; rreg(7);
        // R8 / R9 DMA send
        wreg(3, 8'h00); {b_msg, b_cd, b_io} = 0;
        wreg(2, 8'h02); wreg(5, 8'hEE); b_req = 1; idle(2); rreg(5);
        wreg(0, 8'h5A); idle(1); b_req = 0; idle(2); rreg(5);
        // R10 initiator receive
        wreg(7, 8'h00); b_req = 1; idle(2); bd = 8'hC3; rreg(0); idle(1); b_req = 0; idle(2);
        // R11 end of DMA: short pulse then full pulse
        eop = 1; dack = 1; hrd = 1; idle(N - 1); eop = 0; rreg(5);
        eop = 1; hrd = 0; hwr = 1; idle(N); eop = 0; hwr = 0; dack = 0; rreg(5);
        wreg(2, 8'h00); rreg(5);
        // R12 / R13 interrupt
        wreg(2, 8'h02); b_msg = 1; b_req = 1; idle(2); rreg(5); idle(3);
        b_req = 0; rreg(7); rreg(5);
        b_msg = 0; b_req = 1; idle(2); b_req = 0;
        wreg(2, 8'h42); b_msg = 1; b_req = 1; idle(2); rreg(5); b_req = 0;
        wreg(2, 8'h02); b_req = 1; a = 7; rd = 1; step(); rd = 0; rreg(5); b_req = 0;
        rreg(7); idle(3);
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule